// File: doc/BRIEF.md
# Two-Port Semaphore Token Unit

This block holds a bank of hardware semaphores that two agents, a left port and a right port, use to claim shared resources. The semaphores are separate from any data memory. Each port has a semaphore select, a write strobe, a read strobe, an address and a data bus. A port claims a token by writing 0 on data bit 0 and gives it back by writing 1. A read returns the token state as that port sees it: 0 means "this port owns it" and 1 means "not mine". The read result is copied onto every data line.

Each semaphore keeps one request latch per side. A request from the side that does not hold the token is remembered. That side gets the token in the same cycle the owner lets go. When both sides claim a free token in the same cycle, the left port wins. Read data is registered. A read samples the state as it stood before any write made in the same cycle, and the result holds until that port's next legal read. A select asserted together with the port's ordinary memory enable is an illegal combination, and the block ignores that access.

Top module: `sem_token_unit`

## Requirements
- R1: The semaphore index is address bits [2:0], giving eight independent semaphores. Address bits [11:3] have no effect.
- R2: A legal write uses only data bit 0: 0 sets that port's request and 1 clears it. Data bits [7:1] have no effect.
- R3: When one port requests a free semaphore, that port then reads 8'h00 and the other port reads 8'hFF.
- R4: A request from the non-owner while the semaphore is held leaves both ports' read values unchanged.
- R5: When the owner writes 1 while the other port has a request pending, ownership passes to the other port on the same clock edge.
- R6: When the owner writes 1 and no request is pending from the other port, the semaphore becomes free and both ports read 8'hFF.
- R7: A non-owner that writes 1 cancels its pending request, so a later release by the owner leaves the semaphore free.
- R8: A legal read loads rdata, one cycle after the strobe, with the port's view (0 = owned by this port, 1 = not) on all 8 lines. The value reflects the state before any write in the same cycle and holds until the next legal read by that port.
- R9: When both ports request the same free semaphore in the same cycle, the left port becomes the owner.
- R10: An access with both select and mem_en high is ignored. It changes no semaphore and does not reload rdata.
- R11: Synchronous reset frees every semaphore, clears all requests, and sets both rdata buses to 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left ordinary memory enable (illegal together with select) |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_addr | input | 12 | Left address; bits [2:0] select the semaphore |
| l_wdata | input | 8 | Left write data; bit 0 used |
| l_rdata | output | 8 | Left registered read data |
| r_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right ordinary memory enable (illegal together with select) |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_addr | input | 12 | Right address; bits [2:0] select the semaphore |
| r_wdata | input | 8 | Right write data; bit 0 used |
| r_rdata | output | 8 | Right registered read data |

## Verification
The assertions check on every cycle, for each semaphore, the ownership transitions that follow a write:
- a pending request is granted on release;
- a release with nothing pending frees the token;
- a non-owner's request leaves the owner in place;
- a cancel clears the pending request;
- the left port wins a same-cycle tie.

They also check that rdata is always uniform across its lines and never changes after an illegal access.

Only the bench scenarios can show the following:
- the value a port actually reads back after a sequence of operations;
- that upper address bits and upper data bits have no effect;
- that semaphores are independent of each other;
- that a read in the same cycle as the other side's release returns the earlier state.

// File: rtl/sem_token_pkg.sv
package sem_token_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } sem_owner_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic              sel,
  input  logic              mem_en,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_SEM-1:0] wen,
  output logic              wbit,
  output logic              rd_ok,
  output logic [IDX_W-1:0]  idx
);
  logic legal;
  logic unused_bits;

  assign legal = sel & ~mem_en;
  assign idx   = addr[IDX_W-1:0];
  assign wbit  = wdata[0];
  assign rd_ok = legal & rd;

  genvar g;
  generate
    for (g = 0; g < NUM_SEM; g++) begin : g_wen
      assign wen[g] = legal & wr & (idx == IDX_W'(g));
    end
  endgenerate

  // upper address and data bits play no part in semaphore access
  assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_token_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wl_en,
  input  logic wl_d,
  input  logic wr_en,
  input  logic wr_d,
  output logic view_l,
  output logic view_r
);
  logic       req_l, req_r, req_l_n, req_r_n;
  sem_owner_e owner, owner_n;

  assign req_l_n = wl_en ? ~wl_d : req_l;
  assign req_r_n = wr_en ? ~wr_d : req_r;

  always_comb begin
    owner_n = owner;
    unique case (owner)
      OWN_LEFT:  owner_n = req_l_n ? OWN_LEFT  : (req_r_n ? OWN_RIGHT : OWN_NONE);
      OWN_RIGHT: owner_n = req_r_n ? OWN_RIGHT : (req_l_n ? OWN_LEFT  : OWN_NONE);
      default:   owner_n = req_l_n ? OWN_LEFT  : (req_r_n ? OWN_RIGHT : OWN_NONE);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_l <= 1'b0;
      req_r <= 1'b0;
      owner <= OWN_NONE;
    end else begin
      req_l <= req_l_n;
      req_r <= req_r_n;
      owner <= owner_n;
    end
  end

  assign view_l = (owner != OWN_LEFT);
  assign view_r = (owner != OWN_RIGHT);

  // R5: pending request granted on release
  p_grant_on_release_r5: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && req_r && wl_en && wl_d && !wr_en) |=> (owner == OWN_RIGHT));
  // R6: release with nothing pending frees the token
  p_free_on_release_r6: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_RIGHT && !req_l && wr_en && wr_d && !wl_en) |=> (owner == OWN_NONE));
  // R4: non-owner request does not displace the owner
  p_hold_owner_r4: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && wr_en && !wr_d && !wl_en) |=> (owner == OWN_LEFT));
  // R7: non-owner writing 1 clears its request
  p_cancel_r7: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_LEFT && wr_en && wr_d) |=> !req_r);
  // R9: left wins a tie on a free token
  p_tie_left_r9: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_NONE && wl_en && !wl_d && wr_en && !wr_d) |=> (owner == OWN_LEFT));
endmodule

// File: rtl/sem_token_unit.sv
module sem_token_unit #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  parameter int NUM_SEM = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_mem_en,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_mem_en,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int IDX_W = $clog2(NUM_SEM);

  logic [NUM_SEM-1:0] l_wen, r_wen, view_l, view_r;
  logic               l_wbit, r_wbit, l_rd_ok, r_rd_ok;
  logic [IDX_W-1:0]   l_idx, r_idx;

  sem_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_l (
    .sel(l_sel), .mem_en(l_mem_en), .wr(l_wr), .rd(l_rd), .addr(l_addr), .wdata(l_wdata),
    .wen(l_wen), .wbit(l_wbit), .rd_ok(l_rd_ok), .idx(l_idx));

  sem_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_r (
    .sel(r_sel), .mem_en(r_mem_en), .wr(r_wr), .rd(r_rd), .addr(r_addr), .wdata(r_wdata),
    .wen(r_wen), .wbit(r_wbit), .rd_ok(r_rd_ok), .idx(r_idx));

  genvar g;
  generate
    for (g = 0; g < NUM_SEM; g++) begin : g_cell
      sem_cell u_cell (
        .clk(clk), .rst(rst),
        .wl_en(l_wen[g]), .wl_d(l_wbit),
        .wr_en(r_wen[g]), .wr_d(r_wbit),
        .view_l(view_l[g]), .view_r(view_r[g]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      l_rdata <= '1;
      r_rdata <= '1;
    end else begin
      if (l_rd_ok) l_rdata <= {DATA_W{view_l[l_idx]}};
      if (r_rd_ok) r_rdata <= {DATA_W{view_r[r_idx]}};
    end
  end

  // R8: read data is always uniform across its lines
  p_uniform_r8: assert property (@(posedge clk) disable iff (rst)
    ((l_rdata == '0) || (l_rdata == '1)) && ((r_rdata == '0) || (r_rdata == '1)));
  // R10: illegal access never reloads read data
  p_illegal_left_r10: assert property (@(posedge clk) disable iff (rst)
    (l_sel && l_mem_en) |=> $stable(l_rdata));
  p_illegal_right_r10: assert property (@(posedge clk) disable iff (rst)
    (r_sel && r_mem_en) |=> $stable(r_rdata));
endmodule

// File: tb/sem_token_unit_tb_top.sv
`timescale 1ns/1ps
module sem_token_unit_tb_top;
  localparam int OP_NONE = 0, OP_WR = 1, OP_RD = 2, OP_ILW = 3, OP_ILR = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic l_sel = 0, l_mem_en = 0, l_wr = 0, l_rd = 0;
  logic r_sel = 0, r_mem_en = 0, r_wr = 0, r_rd = 0;
  logic [11:0] l_addr = '0, r_addr = '0;
  logic [7:0]  l_wdata = '0, r_wdata = '0;
  logic [7:0]  l_rdata, r_rdata;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t ql[$];
  exp_t qr[$];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sem_token_unit dut_i (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_rd(l_rd),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_rd(r_rd),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, applies one cycle of ops, pushes expected reads
  task automatic step(input int lop, input logic [11:0] la, input logic [7:0] ld, input logic [7:0] le,
                      input int rop, input logic [11:0] ra, input logic [7:0] rd, input logic [7:0] re,
                      input string tag);
    l_sel = (lop != OP_NONE); l_mem_en = (lop == OP_ILW || lop == OP_ILR);
    l_wr = (lop == OP_WR || lop == OP_ILW); l_rd = (lop == OP_RD || lop == OP_ILR);
    l_addr = la; l_wdata = ld;
    r_sel = (rop != OP_NONE); r_mem_en = (rop == OP_ILW || rop == OP_ILR);
    r_wr = (rop == OP_WR || rop == OP_ILW); r_rd = (rop == OP_RD || rop == OP_ILR);
    r_addr = ra; r_wdata = rd;
    if (lop == OP_RD) ql.push_back('{le, {tag, " left"}});
    if (rop == OP_RD) qr.push_back('{re, {tag, " right"}});
    @(negedge clk);
    l_sel = 0; l_mem_en = 0; l_wr = 0; l_rd = 0;
    r_sel = 0; r_mem_en = 0; r_wr = 0; r_rd = 0;
  endtask

  // monitor: sample legal read strobes at the edge, compare after it
  initial begin
    forever begin
      logic pl, pr;
      @(posedge clk);
      pl = !rst && l_sel && l_rd && !l_mem_en;
      pr = !rst && r_sel && r_rd && !r_mem_en;
      @(negedge clk);
      if (pl) begin
        if (ql.size() == 0) check("left queue empty", 8'hxx, 8'h00);
        else begin exp_t e; e = ql.pop_front(); check(e.tag, l_rdata, e.val); end
      end
      if (pr) begin
        if (qr.size() == 0) check("right queue empty", 8'hxx, 8'h00);
        else begin exp_t e; e = qr.pop_front(); check(e.tag, r_rdata, e.val); end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    check("R11 left rdata after reset", l_rdata, 8'hFF);
    check("R11 right rdata after reset", r_rdata, 8'hFF);
    step(OP_RD, 12'h003, 8'h00, 8'hFF, OP_RD, 12'h003, 8'h00, 8'hFF, "R11 free after reset");
    // R2 R3 R1: left requests with upper data bits set; upper address bits vary
    step(OP_WR, 12'h003, 8'hFE, 8'h00, OP_NONE, 12'h0, 8'h0, 8'h00, "R2 request");
    step(OP_RD, 12'hF03, 8'h00, 8'h00, OP_RD, 12'h503, 8'h00, 8'hFF, "R3 R1 owner view");
    // R4: right requests while held
    step(OP_NONE, 12'h0, 8'h0, 8'h00, OP_WR, 12'h003, 8'h00, 8'h00, "R4 request");
    step(OP_RD, 12'h003, 8'h00, 8'h00, OP_RD, 12'h003, 8'h00, 8'hFF, "R4 no change");
    // R5: left releases, right pending
    step(OP_WR, 12'h003, 8'h01, 8'h00, OP_NONE, 12'h0, 8'h0, 8'h00, "R5 release");
    step(OP_RD, 12'h003, 8'h00, 8'hFF, OP_RD, 12'h003, 8'h00, 8'h00, "R5 handover");
    // R7: left requests, then cancels; right release leaves it free
    step(OP_WR, 12'h003, 8'h00, 8'h00, OP_NONE, 12'h0, 8'h0, 8'h00, "R7 request");
    step(OP_RD, 12'h003, 8'h00, 8'hFF, OP_RD, 12'h003, 8'h00, 8'h00, "R4 held by right");
    step(OP_WR, 12'h003, 8'hFF, 8'h00, OP_NONE, 12'h0, 8'h0, 8'h00, "R7 cancel");
    step(OP_NONE, 12'h0, 8'h0, 8'h00, OP_WR, 12'h003, 8'h01, 8'h00, "R6 release");
    step(OP_RD, 12'h003, 8'h00, 8'hFF, OP_RD, 12'h003, 8'h00, 8'hFF, "R7 R6 free");
    // R1: independence of semaphores
    step(OP_WR, 12'h805, 8'h00, 8'h00, OP_NONE, 12'h0, 8'h0, 8'h00, "R1 request idx5");
    step(OP_RD, 12'h003, 8'h00, 8'hFF, OP_RD, 12'h005, 8'h00, 8'hFF, "R1 other idx");
    step(OP_RD, 12'h005, 8'h00, 8'h00, OP_NONE, 12'h0, 8'h0, 8'h00, "R1 idx5 owner");
    step(OP_WR, 12'h005, 8'hFF, 8'h00, OP_NONE, 12'h0, 8'h0, 8'h00, "R6 release idx5");
    step(OP_RD, 12'h005, 8'h00, 8'hFF, OP_RD, 12'h005, 8'h00, 8'hFF, "R6 idx5 free");
    // R9: simultaneous request
    step(OP_WR, 12'h002, 8'h00, 8'h00, OP_WR, 12'h002, 8'h00, 8'h00, "R9 tie");
    step(OP_RD, 12'h002, 8'h00, 8'h00, OP_RD, 12'h002, 8'h00, 8'hFF, "R9 left wins");
    // R8: right read in the same cycle as left release returns the earlier state
    step(OP_WR, 12'h002, 8'h01, 8'h00, OP_RD, 12'h002, 8'h00, 8'hFF, "R8 snapshot");
    step(OP_RD, 12'h002, 8'h00, 8'hFF, OP_RD, 12'h002, 8'h00, 8'h00, "R8 R5 after release");
    step(OP_NONE, 12'h0, 8'h0, 8'h00, OP_NONE, 12'h0, 8'h0, 8'h00, "idle");
    check("R8 left hold", l_rdata, 8'hFF);
    check("R8 right hold", r_rdata, 8'h00);
    step(OP_NONE, 12'h0, 8'h0, 8'h00, OP_WR, 12'h002, 8'h01, 8'h00, "R6 release idx2");
    step(OP_RD, 12'h002, 8'h00, 8'hFF, OP_RD, 12'h002, 8'h00, 8'hFF, "R6 idx2 free");
    // R10: illegal write ignored
    step(OP_ILW, 12'h004, 8'h00, 8'h00, OP_NONE, 12'h0, 8'h0, 8'h00, "R10 illegal write");
    step(OP_RD, 12'h004, 8'h00, 8'hFF, OP_RD, 12'h004, 8'h00, 8'hFF, "R10 write ignored");
    // R10: illegal read does not reload rdata
    step(OP_WR, 12'h004, 8'h00, 8'h00, OP_NONE, 12'h0, 8'h0, 8'h00, "R10 legal request");
    step(OP_RD, 12'h004, 8'h00, 8'h00, OP_NONE, 12'h0, 8'h0, 8'h00, "R10 legal read");
    step(OP_ILR, 12'h003, 8'h00, 8'h00, OP_ILR, 12'h004, 8'h00, 8'h00, "R10 illegal read");
    check("R10 left rdata kept", l_rdata, 8'h00);
    check("R10 right rdata kept", r_rdata, 8'hFF);
    step(OP_WR, 12'h004, 8'h01, 8'h00, OP_NONE, 12'h0, 8'h0, 8'h00, "R6 release idx4");
    step(OP_RD, 12'h004, 8'h00, 8'hFF, OP_RD, 12'h004, 8'h00, 8'hFF, "R6 idx4 free");
    repeat (2) @(negedge clk);
    if (ql.size() != 0 || qr.size() != 0) check("scoreboard drained", 8'(ql.size() + qr.size()), 8'h00);
    finish_run();
  end
endmodule